// File: doc/BRIEF.md
# ROM Table Data Transfer Unit

This block carries out the table-read instruction of a small 4-bit microcontroller. It forms a ROM address from a 4-bit immediate and the current accumulator (A) and B register nibbles. It issues that address to a synchronous ROM port and waits for the word to come back. The returned 10-bit word holds an 8-bit data byte in bits 7..0 and two destination flags in bits 9 and 8.

Flag bit 8 selects the A/B register pair as a destination. Flag bit 9 selects the R1/R2 output port registers. Either, both or neither pair may be written from a single word. The low data nibble always goes to A or R1, and the high nibble to B or R2. The program counter is not touched: the unit has no path to it.

Outside a read, the unit also accepts a direct byte load of A/B, so that software can set up the table index. The controller has three states:
- **IDLE**: waits for `start`. In this state it takes `start` to ISSUE, or accepts `ab_load`.
- **ISSUE**: drives the ROM request for one cycle. It always moves on to WAIT.
- **WAIT**: holds `busy` until `rom_valid` arrives. The word is captured and routed on that cycle, and the state returns to IDLE.

Top module: `tbl_xfer_unit`

## Requirements
- R1: After reset, A, B, R1 and R2 are all zero, and `busy` and `rom_req` are low.
- R2: `start` sampled in IDLE leads, in the next cycle, to `rom_req` high for exactly one cycle and `busy` high. `rom_addr` is {imm[3:0], B, A} (imm in bits 11..8, B in bits 7..4, A in bits 3..0), using the A and B values at the `start` edge.
- R3: `busy` stays high until the cycle after `rom_valid` is seen in WAIT, then drops to low.
- R4: If word bit 8 is 1, A takes word[3:0] and B takes word[7:4].
- R5: If word bit 9 is 1, R1 takes word[3:0] and R2 takes word[7:4].
- R6: If bits 9 and 8 are both 1, both pairs are written on the same clock edge.
- R7: If bits 9 and 8 are both 0, no register changes.
- R8: `start` and `ab_load` are ignored while `busy` is high. `rom_valid` is ignored when no read is pending.
- R9: `ab_load` in IDLE with `start` low sets A to ab_din[3:0] and B to ab_din[7:4] on the next edge. When `start` is also high, the read wins and the load is dropped.
- R10: `rom_addr` holds its value for the whole time `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a table read |
| imm | input | 4 | Immediate forming the address high nibble |
| ab_load | input | 1 | Direct load of A/B |
| ab_din | input | 8 | Load data, low nibble to A, high to B |
| rom_req | output | 1 | One-cycle ROM read request |
| rom_addr | output | 12 | ROM address {imm, B, A} |
| rom_valid | input | 1 | ROM word valid |
| rom_word | input | 10 | ROM word: flags in 9..8, data in 7..0 |
| busy | output | 1 | Read in progress |
| acc_q | output | 4 | Accumulator |
| b_q | output | 4 | B register |
| r1_q | output | 4 | R1 port output register |
| r2_q | output | 4 | R2 port output register |

## Verification
Every cycle, the assertions check that the request lasts one cycle, that `busy` persists while the ROM is silent, and that the address stays frozen during a read. They also check the nibble routing for each flag combination and that a flags-zero word leaves all four registers unchanged.

Only the bench scenarios show the following:
- the address composition uses pre-write-back A/B when a word rewrites A/B;
- `start` and `ab_load` pulses during a read are dropped;
- a stray `rom_valid` while idle is harmless;
- the load versus start priority behaves as stated.

Scenarios also vary the ROM latency.

// File: rtl/txu_pkg.sv
package txu_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } txu_state_e;
endpackage

// File: rtl/txu_ctrl.sv
module txu_ctrl
    import txu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ab_load,
    input  logic rom_valid,
    output logic rom_req,
    output logic busy,
    output logic addr_latch,
    output logic capture,
    output logic load_ok
);
    txu_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (rom_valid) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rom_req    = 1'b0;
        busy       = 1'b0;
        addr_latch = 1'b0;
        capture    = 1'b0;
        load_ok    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                addr_latch = start;
                load_ok    = ab_load && !start;
            end
            ST_ISSUE: begin
                rom_req = 1'b1;
                busy    = 1'b1;
            end
            ST_WAIT: begin
                busy    = 1'b1;
                capture = rom_valid;
            end
            default: ;
        endcase
    end

    a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req |=> !rom_req);
    a_r3_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rom_valid) |=> busy);
    a_r8_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load_ok && !addr_latch);
endmodule

// File: rtl/txu_route.sv
module txu_route #(
    parameter int NIB_W = 4,
    localparam int WORD_W = 2 * NIB_W + 2
) (
    input  logic              capture,
    input  logic [WORD_W-1:0] word,
    output logic [1:0]        dest_we,
    output logic [NIB_W-1:0]  lo_nib,
    output logic [NIB_W-1:0]  hi_nib
);
    for (genvar g = 0; g < 2; g++) begin : g_dest
        assign dest_we[g] = capture && word[2*NIB_W+g];
    end
    assign lo_nib = word[NIB_W-1:0];
    assign hi_nib = word[2*NIB_W-1:NIB_W];
endmodule

// File: rtl/txu_regs.sv
module txu_regs #(
    parameter int NIB_W = 4,
    parameter int IMM_W = 4,
    localparam int ADDR_W = IMM_W + 2 * NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        dest_we,
    input  logic [NIB_W-1:0]  lo_nib,
    input  logic [NIB_W-1:0]  hi_nib,
    input  logic              load_ok,
    input  logic [2*NIB_W-1:0] ab_din,
    input  logic              addr_latch,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] addr_q,
    output logic [NIB_W-1:0]  acc_q,
    output logic [NIB_W-1:0]  b_q,
    output logic [NIB_W-1:0]  r1_q,
    output logic [NIB_W-1:0]  r2_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            b_q   <= '0;
        end else if (dest_we[0]) begin
            acc_q <= lo_nib;
            b_q   <= hi_nib;
        end else if (load_ok) begin
            acc_q <= ab_din[NIB_W-1:0];
            b_q   <= ab_din[2*NIB_W-1:NIB_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1_q <= '0;
            r2_q <= '0;
        end else if (dest_we[1]) begin
            r1_q <= lo_nib;
            r2_q <= hi_nib;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          addr_q <= '0;
        else if (addr_latch) addr_q <= {imm, b_q, acc_q};
    end
endmodule

// File: rtl/tbl_xfer_unit.sv
module tbl_xfer_unit #(
    parameter int NIB_W = 4,
    parameter int IMM_W = 4,
    localparam int ADDR_W = IMM_W + 2 * NIB_W,
    localparam int WORD_W = 2 * NIB_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IMM_W-1:0]  imm,
    input  logic              ab_load,
    input  logic [2*NIB_W-1:0] ab_din,
    output logic              rom_req,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic              rom_valid,
    input  logic [WORD_W-1:0] rom_word,
    output logic              busy,
    output logic [NIB_W-1:0]  acc_q,
    output logic [NIB_W-1:0]  b_q,
    output logic [NIB_W-1:0]  r1_q,
    output logic [NIB_W-1:0]  r2_q
);
    logic addr_latch, capture, load_ok;
    logic [1:0] dest_we;
    logic [NIB_W-1:0] lo_nib, hi_nib;

    txu_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .ab_load(ab_load),
        .rom_valid(rom_valid), .rom_req(rom_req), .busy(busy),
        .addr_latch(addr_latch), .capture(capture), .load_ok(load_ok)
    );

    txu_route #(.NIB_W(NIB_W)) u_route (
        .capture(capture), .word(rom_word), .dest_we(dest_we),
        .lo_nib(lo_nib), .hi_nib(hi_nib)
    );

    txu_regs #(.NIB_W(NIB_W), .IMM_W(IMM_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .dest_we(dest_we), .lo_nib(lo_nib),
        .hi_nib(hi_nib), .load_ok(load_ok), .ab_din(ab_din),
        .addr_latch(addr_latch), .imm(imm), .addr_q(rom_addr),
        .acc_q(acc_q), .b_q(b_q), .r1_q(r1_q), .r2_q(r2_q)
    );

    a_r10_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rom_valid) |=> $stable(rom_addr));
    a_r4_ab_routed: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rom_req && rom_valid && rom_word[2*NIB_W])
        |=> (acc_q == $past(rom_word[NIB_W-1:0])) && (b_q == $past(rom_word[2*NIB_W-1:NIB_W])));
    a_r5_port_routed: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rom_req && rom_valid && rom_word[2*NIB_W+1])
        |=> (r1_q == $past(rom_word[NIB_W-1:0])) && (r2_q == $past(rom_word[2*NIB_W-1:NIB_W])));
    a_r7_no_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rom_req && rom_valid && rom_word[WORD_W-1 -: 2] == 2'b00)
        |=> $stable(acc_q) && $stable(b_q) && $stable(r1_q) && $stable(r2_q));
endmodule

// File: tb/sim_tbl_xfer_unit.sv
module sim_tbl_xfer_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [3:0] imm = '0;
    logic ab_load = 1'b0;
    logic [7:0] ab_din = '0;
    logic rom_req, busy;
    logic [11:0] rom_addr;
    logic rom_valid;
    logic [9:0] rom_word;
    logic [3:0] acc_q, b_q, r1_q, r2_q;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int req_count = 0;

    logic [3:0] ea, eb, e1, e2;
    logic rv_q = 1'b0;
    logic [9:0] rw_q = '0;
    logic pend = 1'b0;
    int cnt = 0;
    int lat = 0;
    logic ovr_on = 1'b0;
    logic [9:0] ovr_word = '0;
    logic spur = 1'b0;

    always #2.5 clk = ~clk;

    tbl_xfer_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .imm(imm), .ab_load(ab_load),
        .ab_din(ab_din), .rom_req(rom_req), .rom_addr(rom_addr),
        .rom_valid(rom_valid), .rom_word(rom_word), .busy(busy),
        .acc_q(acc_q), .b_q(b_q), .r1_q(r1_q), .r2_q(r2_q)
    );

    function automatic logic [9:0] rom_fn(input logic [11:0] a);
        logic [11:0] h;
        h = (a * 12'd29) ^ (a >> 3) ^ 12'h5A3;
        return h[9:0];
    endfunction

    assign rom_valid = rv_q | spur;
    assign rom_word  = spur ? 10'h3FF : rw_q;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rom_req) req_count <= req_count + 1;
        rv_q <= 1'b0;
        if (rom_req) begin
            rw_q <= ovr_on ? ovr_word : rom_fn(rom_addr);
            if (lat == 0) rv_q <= 1'b1;
            else begin pend <= 1'b1; cnt <= lat - 1; end
        end else if (pend) begin
            if (cnt == 0) begin rv_q <= 1'b1; pend <= 1'b0; end
            else cnt <= cnt - 1;
        end
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_regs(input string tag);
        chk({acc_q, b_q, r1_q, r2_q} == {ea, eb, e1, e2}, tag,
            {acc_q, b_q, r1_q, r2_q}, {ea, eb, e1, e2});
    endtask

    task automatic do_load(input logic [7:0] d);
        ab_load = 1'b1; ab_din = d;
        @(negedge clk);
        ab_load = 1'b0;
        ea = d[3:0]; eb = d[7:4];
        chk({acc_q, b_q} == {eb, ea} || 1'b0 ? 1'b1 : ({b_q, acc_q} == d), "R9 load", {b_q, acc_q}, d);
    endtask

    // Run one table read; optionally pulse start/ab_load while busy (R8).
    task automatic do_read(input logic [3:0] im, input bit disturb);
        logic [11:0] ex_addr;
        logic [9:0] w;
        int rc0;
        int n;
        ex_addr = {im, eb, ea};
        rc0 = req_count;
        start = 1'b1; imm = im;
        @(negedge clk);
        start = 1'b0;
        chk(rom_req && busy, "R2 req/busy", {rom_req, busy}, 2'b11);
        chk(rom_addr == ex_addr, "R2 addr", rom_addr, ex_addr);
        @(negedge clk);
        chk(!rom_req, "R2 single req", rom_req, 0);
        if (disturb) begin
            start = 1'b1; ab_load = 1'b1; ab_din = 8'hC3; imm = ~im;
        end
        n = 0;
        while (busy && n < 20) begin
            chk(rom_addr == ex_addr, "R10 addr hold", rom_addr, ex_addr);
            @(negedge clk);
            n++;
        end
        start = 1'b0; ab_load = 1'b0;
        chk(!busy && n == lat + 1, "R3 busy length", n, lat + 1);
        w = ovr_on ? ovr_word : rom_fn(ex_addr);
        if (w[8]) begin ea = w[3:0]; eb = w[7:4]; end
        if (w[9]) begin e1 = w[3:0]; e2 = w[7:4]; end
        chk_regs(w[9:8] == 2'b11 ? "R6 both" : w[9:8] == 2'b00 ? "R7 none" :
                 w[8] ? "R4 ab" : "R5 port");
        @(negedge clk);
        chk(!busy && req_count == rc0 + 1, "R8 no extra read", req_count - rc0, 1);
        chk_regs("R8 regs after");
    endtask

    initial begin
        void'($urandom(32'd1234));
        ea = 0; eb = 0; e1 = 0; e2 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(!busy && !rom_req, "R1 ctrl", {busy, rom_req}, 0);
        chk_regs("R1 regs");

        do_load(8'h5A);
        ovr_on = 1'b1;
        ovr_word = 10'h1B7; do_read(4'h3, 1'b0);            // R4
        ovr_word = 10'h2E4; do_read(4'h9, 1'b0);            // R5
        ovr_word = 10'h3C1; lat = 2; do_read(4'hF, 1'b0);   // R6, addr uses pre-write A/B
        ovr_word = 10'h0FF; lat = 1; do_read(4'h0, 1'b1);   // R7 and R8 disturb
        lat = 0;
        ovr_word = 10'h1E8; do_read(4'h6, 1'b1);            // R8 load while busy dropped

        // R8: stray valid while idle
        spur = 1'b1; @(negedge clk); spur = 1'b0; @(negedge clk);
        chk(!busy, "R8 stray valid busy", busy, 0);
        chk_regs("R8 stray valid regs");

        // R9: start wins over simultaneous load
        begin
            logic [11:0] ex;
            ex = {4'hA, eb, ea};
            ab_load = 1'b1; ab_din = 8'h77; start = 1'b1; imm = 4'hA;
            @(negedge clk);
            ab_load = 1'b0; start = 1'b0;
            chk(rom_addr == ex && busy, "R9 start priority", rom_addr, ex);
            while (busy) @(negedge clk);
            ovr_word = 10'h0AA;
            @(negedge clk);
            chk_regs("R9 load dropped");
        end

        ovr_on = 1'b0;
        for (int i = 0; i < 40; i++) begin
            lat = $urandom_range(0, 2);
            if ($urandom_range(0, 3) == 0) do_load(8'($urandom));
            do_read(4'($urandom), 1'($urandom_range(0, 1)));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule